// File: doc/BRIEF.md
# Triangle Batch Buffer

This block gathers triangle records from an incoming 32-bit word stream into on-chip storage. Each triangle is a fixed group of seven words, and up to sixteen triangles make one batch. A batch closes either when the triangle limit is reached or when a reserved terminator value shows up at a triangle boundary. The terminator is not stored. It announces that the triangle that follows is the final one, and the batch closes once that triangle's seventh word is in.

Once a batch closes, the block raises a level start signal for the rasterization logic downstream and stops accepting input. The consumer reads the stored triangle count, then asks for triangles by index. Each request produces the seven words of that triangle as a burst on a valid/ready output stream. A one-cycle done pulse marks the end of the burst for the highest stored index. When the consumer has finished with the batch, it pulses a release input, which empties the buffer and returns it to collecting.

Back-pressure works as follows. On the input side, a word is taken on any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high exactly while the block is collecting. On the output side, a word moves on any cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the current word and its last flag are held.

Top module: `tri_batch_buf`

## Requirements
- R1: After reset, `in_ready` is 1, and `batch_start`, `out_valid`, `batch_done` and `tri_count` are all 0.
- R2: While collecting, `in_ready` is 1. Accepted words are stored in arrival order, seven consecutive words per triangle (word 0 first). `tri_count` rises by one on the cycle after each triangle's seventh word is accepted.
- R3: When the MAX_TRIS-th triangle's seventh word is accepted, `batch_start` is 1 and `in_ready` is 0 from the next cycle. `tri_count` never exceeds MAX_TRIS.
- R4: A word equal to MARKER that arrives at a triangle boundary, before any terminator in the same batch, is not stored. The next triangle is stored normally, and the batch closes (as in R3) after that triangle's seventh word.
- R5: A word equal to MARKER is stored as ordinary data in two cases: when it arrives inside a triangle (word positions 1 to 6), and when a terminator has already been seen in the batch.
- R6: Suppose `rd_req` is high with `rd_idx` < `tri_count`, `batch_start` is 1 and no burst is in flight. Then from the next cycle `out_valid` is 1, and words 0 to 6 of that triangle appear in order. `out_last` is 1 only with word 6.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` stay unchanged.
- R8: `rd_req` is ignored in three cases: when `rd_idx` >= `tri_count`, while a burst is in flight, and while collecting.
- R9: `batch_done` is a one-cycle pulse on the cycle after word 6 of the triangle at index `tri_count`-1 is accepted. It stays 0 for every other triangle.
- R10: While `batch_start` is 1, a `release_batch` pulse makes `batch_start` 0, `in_ready` 1 and `tri_count` 0 on the next cycle, and drops any burst in flight. While collecting, `release_batch` has no effect.
- R11: While `in_ready` is 0, `in_valid` and `in_data` have no effect on the stored contents or on `tri_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Buffer is collecting and accepts a word |
| in_data | input | DATA_W | Input word |
| batch_start | output | 1 | Batch closed, replay allowed (level) |
| tri_count | output | $clog2(MAX_TRIS+1) | Number of complete stored triangles |
| release_batch | input | 1 | Consumer has finished the batch |
| rd_req | input | 1 | Request a triangle burst |
| rd_idx | input | $clog2(MAX_TRIS) | Index of the requested triangle |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Marks word 6 of the burst |
| batch_done | output | 1 | Pulse after the highest-index triangle's burst |

## Verification
The bench builds the block with MAX_TRIS=4, TRI_WORDS=7 and MARKER=32'h5EED_0001. With that triangle limit, a batch can be closed by count after only 28 words. A batch closed early by the terminator with two triangles brings out-of-range indices within reach, even though `rd_idx` is only two bits wide. The bench also places the marker value inside a triangle and right after a terminator, to show that it is stored as data in both positions. It stalls the output stream partway through a burst and replays triangles out of order, so the done pulse is seen to follow the highest index and not the last request.

// File: rtl/tbb_pkg.sv
package tbb_pkg;
  typedef enum logic {
    MODE_FILL   = 1'b0,
    MODE_REPLAY = 1'b1
  } tbb_mode_e;
endpackage

// File: rtl/tbb_store.sv
module tbb_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 112,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Read is combinational so a granted request shows word 0 on the next cycle.
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tbb_fill_ctrl.sv
module tbb_fill_ctrl
  import tbb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter logic [DATA_W-1:0] MARKER = '1,
  parameter int TRI_WORDS = 7,
  parameter int MAX_TRIS  = 16,
  parameter int CNT_W     = 5,
  parameter int WIDX_W    = 3,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              release_i,
  output logic              in_ready,
  output tbb_mode_e         mode,
  output logic [CNT_W-1:0]  count,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  tbb_mode_e         mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WIDX_W-1:0] word_q;
  logic [ADDR_W-1:0] base_q;   // running cnt_q * TRI_WORDS
  logic              tail_q;   // terminator seen in this batch

  logic accept, is_marker, tri_end, close;

  assign accept    = in_valid && (mode_q == MODE_FILL);
  assign is_marker = accept && (in_data == MARKER) && (word_q == '0) && !tail_q;
  assign wr_en     = accept && !is_marker;
  assign wr_addr   = base_q + ADDR_W'(word_q);
  assign wr_data   = in_data;
  assign tri_end   = wr_en && (word_q == WIDX_W'(TRI_WORDS - 1));
  assign close     = tri_end && ((cnt_q == CNT_W'(MAX_TRIS - 1)) || tail_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_FILL;
      cnt_q  <= '0;
      word_q <= '0;
      base_q <= '0;
      tail_q <= 1'b0;
    end else if (mode_q == MODE_FILL) begin
      if (is_marker) tail_q <= 1'b1;
      if (wr_en) begin
        if (tri_end) begin
          word_q <= '0;
          cnt_q  <= cnt_q + CNT_W'(1);
          base_q <= base_q + ADDR_W'(TRI_WORDS);
        end else begin
          word_q <= word_q + WIDX_W'(1);
        end
      end
      if (close) mode_q <= MODE_REPLAY;
    end else if (release_i) begin
      mode_q <= MODE_FILL;
      cnt_q  <= '0;
      word_q <= '0;
      base_q <= '0;
      tail_q <= 1'b0;
    end
  end

  assign in_ready = (mode_q == MODE_FILL);
  assign mode     = mode_q;
  assign count    = cnt_q;
endmodule

// File: rtl/tbb_replay.sv
module tbb_replay
  import tbb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int TRI_WORDS = 7,
  parameter int CNT_W     = 5,
  parameter int IDX_W     = 4,
  parameter int WIDX_W    = 3,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tbb_mode_e         mode,
  input  logic [CNT_W-1:0]  count,
  input  logic              release_i,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              batch_done
);
  logic              busy_q, done_q;
  logic [ADDR_W-1:0] base_q;
  logic [WIDX_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;

  logic in_replay, drop, take, fire, at_last;

  assign in_replay = (mode == MODE_REPLAY);
  assign drop      = in_replay && release_i;
  assign take      = rd_req && in_replay && !busy_q && !release_i
                     && (CNT_W'(rd_idx) < count);
  assign fire      = busy_q && out_ready;
  assign at_last   = (word_q == WIDX_W'(TRI_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      base_q <= '0;
      word_q <= '0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (drop) begin
        busy_q <= 1'b0;
        word_q <= '0;
      end else if (take) begin
        busy_q <= 1'b1;
        base_q <= ADDR_W'(rd_idx) * ADDR_W'(TRI_WORDS);
        idx_q  <= rd_idx;
        word_q <= '0;
      end else if (fire) begin
        if (at_last) begin
          busy_q <= 1'b0;
          word_q <= '0;
          done_q <= (CNT_W'(idx_q) == count - CNT_W'(1));
        end else begin
          word_q <= word_q + WIDX_W'(1);
        end
      end
    end
  end

  assign rd_addr    = base_q + ADDR_W'(word_q);
  assign out_valid  = busy_q;
  assign out_data   = rd_data;
  assign out_last   = busy_q && at_last;
  assign batch_done = done_q;
endmodule

// File: rtl/tri_batch_buf.sv
module tri_batch_buf
  import tbb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter logic [DATA_W-1:0] MARKER = 32'hCAFE_F00D,
  parameter int TRI_WORDS = 7,
  parameter int MAX_TRIS  = 16,
  localparam int DEPTH    = TRI_WORDS * MAX_TRIS,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(MAX_TRIS + 1),
  localparam int IDX_W    = $clog2(MAX_TRIS),
  localparam int WIDX_W   = $clog2(TRI_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              batch_start,
  output logic [CNT_W-1:0]  tri_count,
  input  logic              release_batch,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              batch_done
);
  tbb_mode_e         mode;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  tbb_fill_ctrl #(
    .DATA_W(DATA_W), .MARKER(MARKER), .TRI_WORDS(TRI_WORDS), .MAX_TRIS(MAX_TRIS),
    .CNT_W(CNT_W), .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)
  ) u_fill (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .release_i(release_batch), .in_ready(in_ready), .mode(mode), .count(tri_count),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  tbb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  tbb_replay #(
    .DATA_W(DATA_W), .TRI_WORDS(TRI_WORDS), .CNT_W(CNT_W), .IDX_W(IDX_W),
    .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)
  ) u_replay (
    .clk(clk), .rst_n(rst_n), .mode(mode), .count(tri_count), .release_i(release_batch),
    .rd_req(rd_req), .rd_idx(rd_idx), .out_ready(out_ready), .rd_data(rd_data),
    .rd_addr(rd_addr), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .batch_done(batch_done)
  );

  assign batch_start = (mode == MODE_REPLAY);
endmodule

// File: rtl/tbb_checker.sv
module tbb_checker #(
  parameter int DATA_W   = 32,
  parameter int MAX_TRIS = 16,
  parameter int CNT_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              batch_start,
  input logic [CNT_W-1:0]  tri_count,
  input logic              release_batch,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              batch_done
);
  assert_no_input_in_replay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    batch_start |-> !in_ready);

  assert_close_on_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(batch_start) |-> $past(in_valid && in_ready));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tri_count <= CNT_W'(MAX_TRIS));

  assert_valid_only_in_replay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> batch_start);

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !release_batch) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));

  assert_done_in_replay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |-> (batch_start && !out_valid));

  assert_release_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (batch_start && release_batch) |=> (!batch_start && tri_count == '0));
endmodule

bind tri_batch_buf tbb_checker #(
  .DATA_W(DATA_W), .MAX_TRIS(MAX_TRIS), .CNT_W(CNT_W)
) u_tbb_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .batch_start(batch_start), .tri_count(tri_count), .release_batch(release_batch),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .batch_done(batch_done)
);

// File: tb/tb_tri_batch_buf.sv
module tb_tri_batch_buf;
  localparam int CLK_PERIOD = 10;
  localparam int MAXT = 4;
  localparam logic [31:0] MK = 32'h5EED_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [31:0] in_data = '0;
  logic batch_start, release_batch = 1'b0, rd_req = 1'b0;
  logic [2:0] tri_count;
  logic [1:0] rd_idx = '0;
  logic out_valid, out_ready = 1'b1, out_last, batch_done;
  logic [31:0] out_data;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_batch_buf #(.DATA_W(32), .MARKER(MK), .TRI_WORDS(7), .MAX_TRIS(MAXT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .batch_start(batch_start), .tri_count(tri_count), .release_batch(release_batch),
    .rd_req(rd_req), .rd_idx(rd_idx), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .batch_done(batch_done)
  );

  function automatic logic [31:0] pat(input int b, input int t, input int w);
    return 32'h1000_0000 | (b << 16) | (t << 8) | w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] d);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_tri(input int b, input int t);
    for (int w = 0; w < 7; w++) send_word(pat(b, t, w));
  endtask

  // One burst; ov_w/ov_val override one expected word; stall_w stalls two cycles there.
  task automatic read_tri(input int b, input int idx, input int ov_w, input logic [31:0] ov_val,
                          input int stall_w, input bit exp_done);
    logic [31:0] exp, held;
    rd_req = 1'b1;
    rd_idx = idx[1:0];
    @(negedge clk);
    rd_req = 1'b0;
    for (int w = 0; w < 7; w++) begin
      exp = (w == ov_w) ? ov_val : pat(b, idx, w);
      if (w == stall_w) begin
        out_ready = 1'b0;
        held = out_data;
        @(negedge clk);
        @(negedge clk);
        check(out_valid && out_data == held && out_last == (w == 6), "R7 stall hold", out_data, held);
        out_ready = 1'b1;
      end
      check(out_valid == 1'b1, "R6 valid", {31'b0, out_valid}, 32'd1);
      check(out_data == exp, "R6 data", out_data, exp);
      check(out_last == (w == 6), "R6 last", {31'b0, out_last}, {31'b0, w == 6});
      @(negedge clk);
    end
    check(out_valid == 1'b0, "R6 burst end", {31'b0, out_valid}, 32'd0);
    check(batch_done == exp_done, "R9 done pulse", {31'b0, batch_done}, {31'b0, exp_done});
    @(negedge clk);
    check(batch_done == 1'b0, "R9 one cycle", {31'b0, batch_done}, 32'd0);
  endtask

  task automatic do_release();
    release_batch = 1'b1;
    @(negedge clk);
    release_batch = 1'b0;
  endtask

  task automatic t_reset();
    check(in_ready && !batch_start && !out_valid && !batch_done && tri_count == 0,
          "R1 reset state", {in_ready, batch_start, out_valid, batch_done, 25'b0, tri_count},
          {1'b1, 31'b0});
  endtask

  task automatic t_fill_limit();
    send_tri(1, 0);
    send_tri(1, 1);
    check(tri_count == 2 && in_ready, "R2 partial count", {28'b0, in_ready, tri_count}, 32'h0A);
    send_tri(1, 2);
    send_tri(1, 3);
    check(batch_start == 1'b1, "R3 start at limit", {31'b0, batch_start}, 32'd1);
    check(in_ready == 1'b0, "R3 ready low", {31'b0, in_ready}, 32'd0);
    check(tri_count == 3'(MAXT), "R2 full count", {29'b0, tri_count}, MAXT);
  endtask

  task automatic t_replay_order();
    read_tri(1, 2, -1, '0, -1, 1'b0);
    read_tri(1, 0, -1, '0, -1, 1'b0);
    read_tri(1, 1, -1, '0, 3, 1'b0);
    read_tri(1, 3, -1, '0, 6, 1'b1);
  endtask

  task automatic t_input_ignored();
    in_valid = 1'b1;
    in_data  = 32'hBAD0_BAD0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R11 ready low", {31'b0, in_ready}, 32'd0);
    end
    in_valid = 1'b0;
    check(tri_count == 3'(MAXT), "R11 count kept", {29'b0, tri_count}, MAXT);
    read_tri(1, 0, -1, '0, -1, 1'b0);
  endtask

  task automatic t_busy_request();
    rd_req = 1'b1;
    rd_idx = 2'd0;
    @(negedge clk);
    rd_idx = 2'd2;
    for (int w = 0; w < 7; w++) begin
      check(out_valid && out_data == pat(1, 0, w), "R8 busy request ignored", out_data, pat(1, 0, w));
      @(negedge clk);
      rd_req = 1'b0;
    end
    check(out_valid == 1'b0, "R8 no second burst", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_release();
    do_release();
    check(!batch_start && in_ready && tri_count == 0, "R10 release",
          {batch_start, in_ready, 27'b0, tri_count}, 32'h4000_0000);
  endtask

  task automatic t_marker();
    send_tri(2, 0);
    send_word(MK);
    check(tri_count == 1 && in_ready, "R4 marker not counted", {28'b0, in_ready, tri_count}, 32'h09);
    send_tri(2, 1);
    check(batch_start && tri_count == 2, "R4 close after tail", {28'b0, batch_start, tri_count}, 32'h0A);
    rd_req = 1'b1;
    rd_idx = 2'd3;
    @(negedge clk);
    rd_req = 1'b0;
    check(out_valid == 1'b0, "R8 out of range", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 out of range later", {31'b0, out_valid}, 32'd0);
    read_tri(2, 1, -1, '0, -1, 1'b1);
    read_tri(2, 0, -1, '0, -1, 1'b0);
    do_release();
  endtask

  task automatic t_marker_as_data();
    for (int w = 0; w < 7; w++) send_word(w == 3 ? MK : pat(3, 0, w));
    rd_req = 1'b1;
    rd_idx = 2'd0;
    @(negedge clk);
    rd_req = 1'b0;
    check(out_valid == 1'b0, "R8 request in fill", {31'b0, out_valid}, 32'd0);
    do_release();
    check(tri_count == 1 && in_ready, "R10 release in fill ignored", {28'b0, in_ready, tri_count}, 32'h09);
    send_word(MK);
    for (int w = 0; w < 7; w++) send_word(w == 0 ? MK : pat(3, 1, w));
    check(batch_start && tri_count == 2, "R5 second marker is data", {28'b0, batch_start, tri_count}, 32'h0A);
    read_tri(3, 0, 3, MK, -1, 1'b0);
    read_tri(3, 1, 0, MK, -1, 1'b1);
  endtask

  task automatic t_release_mid_burst();
    rd_req = 1'b1;
    rd_idx = 2'd1;
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
    release_batch = 1'b1;
    @(negedge clk);
    release_batch = 1'b0;
    check(!out_valid && !batch_start && in_ready, "R10 burst dropped",
          {out_valid, batch_start, in_ready, 29'b0}, 32'h2000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_limit();
    t_replay_order();
    t_input_ignored();
    t_busy_request();
    t_release();
    t_marker();
    t_marker_as_data();
    t_release_mid_burst();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule